// File: doc/BRIEF.md
# Page-Mode Asynchronous Memory Read Controller

This block sits between a synchronous host and an asynchronous read-only memory that supports page-mode access. The host issues one read at a time through a valid/ready handshake, giving a byte address and a flag that selects word or byte width. The controller drives chip enable, output enable and the address lines. It holds them for a counted number of clock cycles, then samples the data bus and returns the result as a one-cycle response pulse.

The memory is organised in pages of eight 16-bit words, which is sixteen bytes. The controller remembers the page it last opened for as long as chip enable stays asserted. A read into that open page uses the short page wait. Any other read uses the long initial wait: the first read, a read to another page, or a read after chip enable was dropped. Both waits are clock-cycle counts taken from configuration inputs. Chip enable is dropped, and the open page forgotten, after a configurable number of idle cycles or on request from the host.

Top module: `pmr_ctrl`

## Requirements
- R1: After reset, mem_ce_n and mem_oe_n are 1, rsp_valid is 0 and req_ready is 1, and the first read uses the initial wait.
- R2: A read that is not a page hit returns rsp_valid exactly W cycles after the accepting clock edge, where W is cfg_init_wait.
- R3: A read whose page (req_addr bits AW down to 4) equals the open page, while chip enable has stayed asserted since that page was opened, returns exactly W cycles after acceptance, where W is cfg_page_wait.
- R4: A read to a page different from the open page uses the initial wait and makes the new page the open one.
- R5: A wait count of 0 in either configuration input behaves as a count of 1.
- R6: In word mode (req_byte = 0), mem_addr carries req_addr bits AW down to 1, mem_lsb is 0 regardless of req_addr bit 0, mem_byte_n is 1, and rsp_data is the 16-bit value on mem_dq.
- R7: In byte mode (req_byte = 1), mem_lsb carries req_addr bit 0 and mem_byte_n is 0. The memory returns the selected byte on mem_dq bits 7..0, and rsp_data is that byte with bits 15..8 cleared.
- R8: mem_oe_n is 0 exactly from acceptance until the response edge, chip enable is asserted whenever mem_oe_n is 0, and mem_addr and mem_lsb do not change during an access.
- R9: After cfg_idle_limit consecutive idle cycles with chip enable asserted (0 treated as 1), mem_ce_n returns to 1 and the next read uses the initial wait. A read accepted before that limit is still a page hit.
- R10: A pulse on release_in while idle raises mem_ce_n at the next edge. A pulse during an access is held until the response has been given and then raises mem_ce_n. Either way the next read uses the initial wait.
- R11: rsp_valid is high for exactly one cycle per read, and req_ready stays 0 from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller can accept a read |
| req_addr | input | AW+1 | Byte address; bit 0 selects the byte in byte mode |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | DW | Read word, or zero-extended byte |
| cfg_init_wait | input | CNT_W | Initial-access wait in cycles |
| cfg_page_wait | input | CNT_W | Page-access wait in cycles |
| cfg_idle_limit | input | IDLE_W | Idle cycles before chip enable is dropped |
| release_in | input | 1 | Request to drop chip enable and close the page |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory word address |
| mem_lsb | output | 1 | Byte-select address bit below the word address |
| mem_byte_n | output | 1 | 0 selects byte-wide memory output |
| mem_dq | input | DW | Memory data bus |

## Verification
A wrong open-page record or a stale chip-enable state appears on the very next read as a wrong wait. The response then arrives a different number of cycles after acceptance. If the wait is too short, the memory model returns a poison value instead of real data, so the data check fails in the same cycle. A missed release or idle timeout shows within one cycle as mem_ce_n staying low, and then as a page hit where a miss is due. A wrong byte or word selection shows in the response data of that read.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic {
    PMR_IDLE = 1'b0,
    PMR_WAIT = 1'b1
  } pmr_state_e;

  // A programmed count of zero is treated as the smallest legal count.
  function automatic int unsigned min_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Idle timeout fires on the cycle that would reach the limit.
  function automatic bit idle_expired(input int unsigned idle_cnt,
                                      input int unsigned limit);
    return idle_cnt + 1 >= min_one(limit);
  endfunction

endpackage

// File: rtl/pmr_wait_timer.sv
module pmr_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             expire
);
  import pmr_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] eff_val;

  assign eff_val = CNT_W'(min_one(32'(load_val)));
  assign running = run_q;
  assign expire  = run_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= eff_val;
      run_q <= 1'b1;
    end else if (expire) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R5: a running count never sits at zero, even when zero was programmed
  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

  // R2: a load always starts a wait
  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> running);

endmodule

// File: rtl/pmr_page_track.sv
module pmr_page_track #(
  parameter int PG_W   = 17,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic [PG_W-1:0]   req_page,
  input  logic              release_in,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              hit,
  output logic              ce_on,
  output logic              hold
);
  import pmr_pkg::*;

  logic              open_q;
  logic [PG_W-1:0]   page_q;
  logic [IDLE_W-1:0] idle_q;
  logic              rel_pend_q;
  logic              idle_hit;
  logic              drop;

  assign idle_hit = idle_expired(32'(idle_q), 32'(idle_limit));
  assign drop     = open_q && !busy && !start &&
                    (rel_pend_q || release_in || idle_hit);
  assign hold     = release_in || rel_pend_q;
  assign hit      = open_q && (req_page == page_q);
  assign ce_on    = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      page_q     <= '0;
      idle_q     <= '0;
      rel_pend_q <= 1'b0;
    end else if (start) begin
      open_q <= 1'b1;
      page_q <= req_page;
      idle_q <= '0;
    end else if (busy) begin
      idle_q <= '0;
      if (release_in) rel_pend_q <= 1'b1;
    end else if (drop) begin
      open_q     <= 1'b0;
      idle_q     <= '0;
      rel_pend_q <= 1'b0;
    end else begin
      idle_q     <= open_q ? idle_q + IDLE_W'(1) : '0;
      rel_pend_q <= 1'b0;
    end
  end

  // R10: chip enable is never dropped in the middle of an access
  assert_no_drop_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> !$past(busy));

  // R10: a deferred release blocks new reads until it has been applied
  assert_pend_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pend_q |-> !start);

  // R9: with a steady limit the idle count stays below it while the page is open
  assert_idle_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !busy && $stable(idle_limit)) |->
      (32'(idle_q) < min_one(32'(idle_limit))));

endmodule

// File: rtl/pmr_bus_seq.sv
module pmr_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   req_addr,
  input  logic          req_byte,
  input  logic          expire,
  input  logic          ce_on,
  input  logic [DW-1:0] mem_dq,
  output logic          busy,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_lsb,
  output logic          mem_byte_n,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  import pmr_pkg::*;

  localparam int BYTE_W = DW / 2;

  pmr_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic          lsb_q;
  logic          byte_q;
  logic          oe_q;
  logic          rsp_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] sampled;

  assign sampled = byte_q ? DW'(mem_dq[BYTE_W-1:0]) : mem_dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PMR_IDLE;
      addr_q  <= '0;
      lsb_q   <= 1'b0;
      byte_q  <= 1'b0;
      oe_q    <= 1'b0;
      rsp_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (start) begin
        state_q <= PMR_WAIT;
        addr_q  <= req_addr[AW:1];
        lsb_q   <= req_byte & req_addr[0];
        byte_q  <= req_byte;
        oe_q    <= 1'b1;
      end else if (state_q == PMR_WAIT && expire) begin
        state_q <= PMR_IDLE;
        oe_q    <= 1'b0;
        rsp_q   <= 1'b1;
        data_q  <= sampled;
      end
    end
  end

  assign busy       = (state_q == PMR_WAIT);
  assign mem_oe_n   = !oe_q;
  assign mem_addr   = addr_q;
  assign mem_lsb    = lsb_q;
  assign mem_byte_n = !byte_q;
  assign rsp_valid  = rsp_q;
  assign rsp_data   = data_q;

  // R8: output enable only while the chip is selected
  assert_oe_under_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ce_on);

  // R8: address lines hold still through a wait
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_lsb)));

  // R8: an accepted read opens output enable at once
  assert_oe_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !mem_oe_n);

  // R11: one response cycle per read
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: the timer only expires inside an access
  assert_expire_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> busy);

endmodule

// File: rtl/pmr_ctrl.sv
module pmr_ctrl #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int WORD_SEL_W = 3,
  parameter int CNT_W      = 8,
  parameter int IDLE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW:0]       req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  input  logic [CNT_W-1:0]  cfg_init_wait,
  input  logic [CNT_W-1:0]  cfg_page_wait,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic              release_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_lsb,
  output logic              mem_byte_n,
  input  logic [DW-1:0]     mem_dq
);

  localparam int PG_W = AW - WORD_SEL_W;

  logic             busy;
  logic             start;
  logic             hit;
  logic             ce_on;
  logic             hold;
  logic             expire;
  logic             timer_run;
  logic [PG_W-1:0]  req_page;
  logic [CNT_W-1:0] wait_sel;

  assign req_page  = req_addr[AW:WORD_SEL_W+1];
  assign wait_sel  = hit ? cfg_page_wait : cfg_init_wait;
  assign req_ready = !busy && !hold;
  assign start     = req_valid && req_ready;
  assign mem_ce_n  = !ce_on;

  pmr_page_track #(
    .PG_W  (PG_W),
    .IDLE_W(IDLE_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_page  (req_page),
    .release_in(release_in),
    .idle_limit(cfg_idle_limit),
    .hit       (hit),
    .ce_on     (ce_on),
    .hold      (hold)
  );

  pmr_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .load_val(wait_sel),
    .running (timer_run),
    .expire  (expire)
  );

  pmr_bus_seq #(
    .AW(AW),
    .DW(DW)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_addr  (req_addr),
    .req_byte  (req_byte),
    .expire    (expire),
    .ce_on     (ce_on),
    .mem_dq    (mem_dq),
    .busy      (busy),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_lsb   (mem_lsb),
    .mem_byte_n(mem_byte_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R11: after acceptance the controller refuses further reads
  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready);

  // R2: the bus sequencer and the timer agree on when an access runs
  assert_timer_tracks_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timer_run |-> busy);

endmodule

// File: tb/pmr_ctrl_test.sv
`timescale 1ns/1ps
module pmr_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [7:0]  cfg_init_wait;
  logic [7:0]  cfg_page_wait;
  logic [15:0] cfg_idle_limit;
  logic        release_in = 1'b0;
  logic        mem_ce_n, mem_oe_n, mem_lsb, mem_byte_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq;

  int iw = 6, pw = 2, idl = 1000;
  int checks = 0, errors = 0, cyc = 0;

  assign cfg_init_wait  = 8'(iw);
  assign cfg_page_wait  = 8'(pw);
  assign cfg_idle_limit = 16'(idl);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pmr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cfg_init_wait(cfg_init_wait),
    .cfg_page_wait(cfg_page_wait), .cfg_idle_limit(cfg_idle_limit),
    .release_in(release_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_lsb(mem_lsb), .mem_byte_n(mem_byte_n),
    .mem_dq(mem_dq)
  );

  function automatic logic [15:0] mword(input logic [19:0] wa);
    logic [19:0] t;
    t = wa * 20'h0B5F3;
    return t[15:0] ^ {wa[19:16], 12'hC69};
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Behavioural memory: data only after enough cycles of a stable address
  int          age = 0;
  int          need;
  bit          m_low = 0, m_hit = 0;
  logic [19:0] m_a = '0;
  logic        m_l = 1'b0;
  logic [15:0] mw;

  always @(negedge clk) begin
    if (mem_ce_n) begin
      m_low = 0;
      age = 0;
    end else begin
      if (!m_low || mem_addr != m_a || mem_lsb != m_l) begin
        m_hit = m_low && (mem_addr[19:3] == m_a[19:3]);
        age = 1;
      end else begin
        age = age + 1;
      end
      m_low = 1;
      m_a = mem_addr;
      m_l = mem_lsb;
    end
  end

  always_comb begin
    need = m_hit ? pw : iw;
    if (need < 1) need = 1;
    mw = mword(mem_addr);
    if (mem_ce_n || mem_oe_n) mem_dq = 16'hFFFF;
    else if (age < need)      mem_dq = 16'hBAD0;
    else if (!mem_byte_n)     mem_dq = {8'hEE, mem_lsb ? mw[15:8] : mw[7:0]};
    else                      mem_dq = mw;
  end

  // Scoreboard
  typedef struct {
    logic [15:0] data;
    int          wt;
    int          acc;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  bit   prev_rsp = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n) chk(!mem_ce_n, "R8 oe without ce", mem_ce_n, 0);
      if (prev_rsp) chk(!rsp_valid, "R11 rsp pulse width", rsp_valid, 0);
      prev_rsp = rsp_valid;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
          chk(cyc - e.acc - 1 == e.wt, {e.tag, " wait"}, cyc - e.acc - 1, e.wt);
          chk(mem_oe_n, "R8 oe released at response", mem_oe_n, 1);
        end
      end
    end
  end

  task automatic rd(input logic [19:0] wa, input bit lsb, input bit byt,
                    input bit hit, input string tag);
    exp_t        e;
    logic [15:0] w;
    w = mword(wa);
    e.wt = hit ? pw : iw;
    if (e.wt < 1) e.wt = 1;
    e.data = byt ? {8'h00, lsb ? w[15:8] : w[7:0]} : w;
    e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {wa, lsb};
    req_byte  = byt;
    while (!req_ready) @(negedge clk);
    e.acc = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low in access", req_ready, 0);
    chk(mem_addr == wa, "R6 address lines", mem_addr, wa);
    chk(mem_lsb == (byt & lsb), byt ? "R7 byte select bit" : "R6 low bit ignored",
        mem_lsb, byt & lsb);
    chk(mem_byte_n == !byt, byt ? "R7 byte mode pin" : "R6 word mode pin",
        mem_byte_n, !byt);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n, "R1 reset ce_n", mem_ce_n, 1);
    chk(mem_oe_n, "R1 reset oe_n", mem_oe_n, 1);
    chk(!rsp_valid, "R1 reset rsp_valid", rsp_valid, 0);
    chk(req_ready, "R1 reset ready", req_ready, 1);

    rd(20'h00120, 0, 0, 0, "R1 R2 first read miss");
    rd(20'h00123, 0, 0, 1, "R3 hit");
    rd(20'h00127, 0, 0, 1, "R3 hit last word");
    rd(20'h00121, 0, 0, 1, "R3 hit backwards");
    rd(20'h00128, 0, 0, 0, "R4 next page miss");
    rd(20'h0012F, 0, 0, 1, "R4 new page is open");
    rd(20'h0012A, 1, 1, 1, "R7 high byte hit");
    rd(20'h0012A, 0, 1, 1, "R7 low byte hit");
    rd(20'h00300, 1, 1, 0, "R7 byte miss");
    rd(20'h00300, 1, 0, 1, "R6 word ignores bit0");

    @(negedge clk); release_in = 1'b1;
    @(negedge clk); release_in = 1'b0;
    chk(mem_ce_n, "R10 idle release ce_n", mem_ce_n, 1);
    rd(20'h00301, 0, 0, 0, "R10 after release miss");

    fork
      rd(20'h00440, 0, 0, 0, "R10 read with pending release");
      begin
        repeat (3) @(negedge clk);
        release_in = 1'b1;
        @(negedge clk);
        release_in = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    chk(mem_ce_n, "R10 deferred release ce_n", mem_ce_n, 1);
    rd(20'h00441, 0, 0, 0, "R10 after deferred release miss");

    idl = 5;
    rd(20'h00500, 0, 0, 0, "R9 miss");
    rd(20'h00501, 0, 0, 1, "R9 hit before timeout");
    repeat (8) @(negedge clk);
    chk(mem_ce_n, "R9 timeout ce_n", mem_ce_n, 1);
    chk(mem_oe_n, "R8 idle oe_n", mem_oe_n, 1);
    rd(20'h00502, 0, 0, 0, "R9 after timeout miss");

    idl = 1000; iw = 0; pw = 0;
    rd(20'h00600, 0, 0, 0, "R5 zero init wait");
    rd(20'h00601, 0, 0, 1, "R5 zero page wait");
    rd(20'h00605, 1, 1, 1, "R5 R7 zero wait byte");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule